// File: doc/BRIEF.md
# Interrupt Return Frame Push Sequencer

This block writes the return frame of a gate-based interrupt or exception to stack memory through a word-wide write port. A single-cycle `start` pulse supplies the interrupted context: stack segment and pointer, flags, code segment and instruction pointer. It also supplies an optional 16-bit error code, a privilege-change flag, and the replacement stack segment and pointer to use when privilege changes. The block captures all of these at the start edge and then issues one write per cycle. Each write lowers the stack pointer by 2 first and then stores the word at the new segment:offset.

When privilege changes, the frame goes onto the replacement stack and begins with the interrupted stack segment and pointer. Without a change, the frame goes onto the current stack. A room check against a lower-bound offset input runs before the first write. If the frame does not fit, the block raises a one-cycle stack fault carrying an error code made only of the external-event bit, and it issues no write. After a successful frame, a one-cycle done pulse reports the final segment:pointer and the number of words written.

Top module: `frame_push_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `busy`, `wr_en`, `done` and `fault` are low.
- R2: Without a privilege change (`priv_chg`=0), the words go to segment `cur_ss` in the order flags, code segment, instruction pointer, at offsets `cur_sp`-2, `cur_sp`-4 and `cur_sp`-6.
- R3: With a privilege change (`priv_chg`=1), the words go to segment `new_ss` in the order interrupted SS, interrupted SP, flags, code segment, instruction pointer, starting at offset `new_sp`-2 and stepping down by 2.
- R4: When `has_err`=1, `err_val` is written as one extra word after the instruction pointer, so the frame holds 4 words without a privilege change and 6 with one.
- R5: The frame fits when the starting pointer (zero-extended to 17 bits) is at least `stk_floor` plus 2 times the word count. Equality counts as fitting.
- R6: If the frame does not fit, no write is issued. `fault` is high for exactly the one cycle after the start edge, with `fault_code` = {15'b0, `ext_evt`}, and no done pulse follows.
- R7: The writes of an accepted frame occupy consecutive cycles, one word per cycle. The first write is in the cycle right after the start edge.
- R8: `done` is high for one cycle right after the last write. At that point `done_ss` is the frame segment, `done_sp` is the starting pointer minus 2 times the word count, and `done_words` is the word count.
- R9: A `start` pulse while `busy` is high is ignored. The frame in progress is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a frame push; sampled only when idle |
| cur_ss | input | 16 | Interrupted stack segment |
| cur_sp | input | 16 | Interrupted stack pointer |
| flags_in | input | 16 | Flag word to save |
| cs_in | input | 16 | Return code segment |
| ip_in | input | 16 | Return instruction pointer |
| has_err | input | 1 | An error code is part of the frame |
| err_val | input | 16 | Error code value |
| priv_chg | input | 1 | Switch to the replacement stack |
| new_ss | input | 16 | Replacement stack segment |
| new_sp | input | 16 | Replacement stack pointer |
| stk_floor | input | 16 | Lowest offset the frame may reach |
| ext_evt | input | 1 | External-event bit for the fault code |
| busy | output | 1 | Sequencer is not idle |
| wr_en | output | 1 | Stack write strobe |
| wr_seg | output | 16 | Write segment |
| wr_off | output | 16 | Write offset |
| wr_data | output | 16 | Write data |
| done | output | 1 | Frame complete pulse |
| done_ss | output | 16 | Final stack segment |
| done_sp | output | 16 | Final stack pointer |
| done_words | output | 3 | Words written |
| fault | output | 1 | Stack fault pulse |
| fault_code | output | 16 | Stack fault error code |

## Verification
Counting from the rising edge that samples `start`, write k (from 0) of an N-word frame is due in cycle k+1, the done pulse in cycle N+1, and a fault in cycle 1. Idle is due one cycle after done or fault. The bench drives inputs at falling edges and samples at each following falling edge, stepping exactly one cycle per expected word. A missing, late or extra write therefore shows up at once as a field mismatch in that cycle. A start pulse issued in the middle of a frame is checked by confirming that the remaining writes and the done report still match the first frame.

// File: rtl/frame_push_pkg.sv
package frame_push_pkg;
    localparam int WORD_W    = 16;
    localparam int MAX_WORDS = 6;
    localparam int CNT_W     = $clog2(MAX_WORDS + 1);
    localparam int BASE_WORDS = 3;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PUSH,
        ST_DONE,
        ST_FAULT
    } seq_state_e;

    typedef struct packed {
        word_t                  seg;
        word_t                  top;
        cnt_t                   count;
        word_t [MAX_WORDS-1:0]  words;
    } frame_t;

    function automatic logic [WORD_W:0] frame_bytes(input cnt_t n);
        logic [WORD_W:0] wide;
        wide = {{(WORD_W + 1 - CNT_W){1'b0}}, n};
        return wide << 1;
    endfunction
endpackage

// File: rtl/frame_builder.sv
module frame_builder
    import frame_push_pkg::*;
(
    input  word_t  cur_ss,
    input  word_t  cur_sp,
    input  word_t  flags_in,
    input  word_t  cs_in,
    input  word_t  ip_in,
    input  logic   has_err,
    input  word_t  err_val,
    input  logic   priv_chg,
    input  word_t  new_ss,
    input  word_t  new_sp,
    output frame_t frame
);
    always_comb begin
        cnt_t n;
        frame       = '0;
        n           = '0;
        frame.seg   = priv_chg ? new_ss : cur_ss;
        frame.top   = priv_chg ? new_sp : cur_sp;
        if (priv_chg) begin
            frame.words[n] = cur_ss;
            n = n + 1'b1;
            frame.words[n] = cur_sp;
            n = n + 1'b1;
        end
        frame.words[n] = flags_in;
        n = n + 1'b1;
        frame.words[n] = cs_in;
        n = n + 1'b1;
        frame.words[n] = ip_in;
        n = n + 1'b1;
        if (has_err) begin
            frame.words[n] = err_val;
            n = n + 1'b1;
        end
        frame.count = n;
    end
endmodule

// File: rtl/room_check.sv
module room_check
    import frame_push_pkg::*;
(
    input  word_t top,
    input  word_t floor_off,
    input  cnt_t  count,
    output logic  fits
);
    logic [WORD_W:0] need;

    always_comb begin
        need = {1'b0, floor_off} + frame_bytes(count);
        fits = ({1'b0, top} >= need);
    end
endmodule

// File: rtl/push_fsm.sv
module push_fsm
    import frame_push_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  frame_t frame_in,
    input  logic   fits_in,
    input  logic   ext_in,
    output logic   busy,
    output logic   wr_en,
    output word_t  wr_seg,
    output word_t  wr_off,
    output word_t  wr_data,
    output logic   done,
    output word_t  done_ss,
    output word_t  done_sp,
    output cnt_t   done_words,
    output logic   fault,
    output word_t  fault_code
);
    seq_state_e state;
    frame_t     frm;
    cnt_t       idx;
    word_t      off;
    logic       ext_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            frm   <= '0;
            idx   <= '0;
            off   <= '0;
            ext_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        frm   <= frame_in;
                        idx   <= '0;
                        off   <= frame_in.top - word_t'(2);
                        ext_q <= ext_in;
                        state <= fits_in ? ST_PUSH : ST_FAULT;
                    end
                end
                ST_PUSH: begin
                    if (idx == frm.count - 1'b1) begin
                        state <= ST_DONE;
                    end else begin
                        idx <= idx + 1'b1;
                        off <= off - word_t'(2);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy       = (state != ST_IDLE);
        wr_en      = (state == ST_PUSH);
        wr_seg     = frm.seg;
        wr_off     = off;
        wr_data    = frm.words[idx];
        done       = (state == ST_DONE);
        done_ss    = frm.seg;
        done_sp    = off;
        done_words = frm.count;
        fault      = (state == ST_FAULT);
        fault_code = fault ? {{(WORD_W - 1){1'b0}}, ext_q} : '0;
    end
endmodule

// File: rtl/frame_push_seq.sv
module frame_push_seq
    import frame_push_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [15:0] cur_ss,
    input  logic [15:0] cur_sp,
    input  logic [15:0] flags_in,
    input  logic [15:0] cs_in,
    input  logic [15:0] ip_in,
    input  logic        has_err,
    input  logic [15:0] err_val,
    input  logic        priv_chg,
    input  logic [15:0] new_ss,
    input  logic [15:0] new_sp,
    input  logic [15:0] stk_floor,
    input  logic        ext_evt,
    output logic        busy,
    output logic        wr_en,
    output logic [15:0] wr_seg,
    output logic [15:0] wr_off,
    output logic [15:0] wr_data,
    output logic        done,
    output logic [15:0] done_ss,
    output logic [15:0] done_sp,
    output logic [2:0]  done_words,
    output logic        fault,
    output logic [15:0] fault_code
);
    frame_t frame;
    logic   fits;

    frame_builder u_build (
        .cur_ss   (cur_ss),
        .cur_sp   (cur_sp),
        .flags_in (flags_in),
        .cs_in    (cs_in),
        .ip_in    (ip_in),
        .has_err  (has_err),
        .err_val  (err_val),
        .priv_chg (priv_chg),
        .new_ss   (new_ss),
        .new_sp   (new_sp),
        .frame    (frame)
    );

    room_check u_room (
        .top       (frame.top),
        .floor_off (stk_floor),
        .count     (frame.count),
        .fits      (fits)
    );

    push_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .frame_in   (frame),
        .fits_in    (fits),
        .ext_in     (ext_evt),
        .busy       (busy),
        .wr_en      (wr_en),
        .wr_seg     (wr_seg),
        .wr_off     (wr_off),
        .wr_data    (wr_data),
        .done       (done),
        .done_ss    (done_ss),
        .done_sp    (done_sp),
        .done_words (done_words),
        .fault      (fault),
        .fault_code (fault_code)
    );
endmodule

// File: rtl/frame_push_chk.sv
module frame_push_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        busy,
    input logic        wr_en,
    input logic [15:0] wr_seg,
    input logic [15:0] wr_off,
    input logic        done,
    input logic [15:0] done_sp,
    input logic [2:0]  done_words,
    input logic        fault
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!busy && !wr_en && !done && !fault));

    assert_offset_step_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(wr_en)) |-> (wr_off == $past(wr_off) - 16'd2));

    assert_segment_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(wr_en)) |-> $stable(wr_seg));

    assert_word_count_R4: assert property (@(posedge clk) disable iff (rst)
        done |-> (done_words >= 3'd3 && done_words <= 3'd6));

    assert_fault_no_write_R6: assert property (@(posedge clk) disable iff (rst)
        fault |-> (!wr_en && !done && $past(start)));

    assert_fault_single_R6: assert property (@(posedge clk) disable iff (rst)
        fault |=> !fault && !wr_en);

    assert_write_busy_R7: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> busy);

    assert_done_follows_write_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(wr_en) && done_sp == $past(wr_off)));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));
endmodule

bind frame_push_seq frame_push_chk u_chk (.*);

// File: tb/frame_push_seq_test.sv
module frame_push_seq_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [15:0] cur_ss, cur_sp, flags_in, cs_in, ip_in, err_val;
    logic        has_err, priv_chg, ext_evt;
    logic [15:0] new_ss, new_sp, stk_floor;
    logic        busy, wr_en, done, fault;
    logic [15:0] wr_seg, wr_off, wr_data, done_ss, done_sp, fault_code;
    logic [2:0]  done_words;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    frame_push_seq uut (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_case(input logic [15:0] ss, input logic [15:0] sp,
                            input logic [15:0] fl, input logic [15:0] cs,
                            input logic [15:0] ip, input logic he,
                            input logic [15:0] ev, input logic pc,
                            input logic [15:0] nss, input logic [15:0] nsp,
                            input logic [15:0] flo, input logic ex,
                            input bit poke);
        logic [15:0] exp_w [6];
        logic [15:0] seg, top;
        int n;
        bit fits;
        n = 0;
        if (pc) begin
            exp_w[n] = ss; n++;
            exp_w[n] = sp; n++;
        end
        exp_w[n] = fl; n++;
        exp_w[n] = cs; n++;
        exp_w[n] = ip; n++;
        if (he) begin exp_w[n] = ev; n++; end
        seg  = pc ? nss : ss;
        top  = pc ? nsp : sp;
        fits = (int'(top) >= int'(flo) + 2 * n);

        @(negedge clk);
        cur_ss = ss; cur_sp = sp; flags_in = fl; cs_in = cs; ip_in = ip;
        has_err = he; err_val = ev; priv_chg = pc; new_ss = nss; new_sp = nsp;
        stk_floor = flo; ext_evt = ex; start = 1'b1;
        @(negedge clk);
        start = 1'b0;

        if (!fits) begin
            // R5 R6: short room gives fault, no write
            chk(fault && !wr_en && fault_code == {15'b0, ex}, "R6",
                {fault, wr_en, fault_code}, {1'b1, 1'b0, 15'b0, ex});
            @(negedge clk);
            chk(!fault && !busy && !done && !wr_en, "R6",
                {fault, busy, done, wr_en}, 4'b0);
            return;
        end

        for (int k = 0; k < n; k++) begin
            logic [15:0] eoff;
            string req;
            eoff = top - 16'(2 * (k + 1));
            req = (he && k == n - 1) ? "R4" : (pc ? "R3" : "R2");
            chk(wr_en && wr_seg == seg && wr_off == eoff && wr_data == exp_w[k], req,
                {wr_en, wr_seg, wr_off, wr_data}, {1'b1, seg, eoff, exp_w[k]});
            if (poke && k == 1) begin
                cur_sp = sp ^ 16'h00F0; new_sp = nsp ^ 16'h0F00;
                flags_in = ~fl; priv_chg = ~pc; start = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
        end

        // R8 R7: done right after last write
        chk(done && !wr_en && done_ss == seg && done_sp == top - 16'(2 * n)
            && done_words == 3'(n), "R8",
            {done, wr_en, done_ss, done_sp, done_words},
            {1'b1, 1'b0, seg, top - 16'(2 * n), 3'(n)});
        @(negedge clk);
        chk(!done && !busy, poke ? "R9" : "R7", {done, busy}, 2'b00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; start = 1'b0;
        cur_ss = '0; cur_sp = '0; flags_in = '0; cs_in = '0; ip_in = '0;
        has_err = 1'b0; err_val = '0; priv_chg = 1'b0; new_ss = '0; new_sp = '0;
        stk_floor = '0; ext_evt = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy && !wr_en && !done && !fault, "R1", {busy, wr_en, done, fault}, 4'b0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !wr_en && !done && !fault, "R1", {busy, wr_en, done, fault}, 4'b0);

        // R2 plain frame, R4 with error code
        run_case(16'h1000, 16'h0200, 16'h0202, 16'h3000, 16'h1234, 1'b0, 16'h0, 1'b0,
                 16'h0, 16'h0, 16'h0100, 1'b0, 1'b0);
        run_case(16'h1000, 16'h0200, 16'h0246, 16'h3000, 16'h4321, 1'b1, 16'h00AA, 1'b0,
                 16'h0, 16'h0, 16'h0100, 1'b0, 1'b0);
        // R3 privilege change, with and without error code
        run_case(16'h1111, 16'h0080, 16'h0002, 16'h2222, 16'h3333, 1'b0, 16'h0, 1'b1,
                 16'h4444, 16'h0800, 16'h0100, 1'b0, 1'b0);
        run_case(16'h1111, 16'h0080, 16'h0002, 16'h2222, 16'h3333, 1'b1, 16'h5A5A, 1'b1,
                 16'h4444, 16'h0800, 16'h0100, 1'b1, 1'b0);
        // R5 exact fit (6 words = 12 bytes) and one short
        run_case(16'h0001, 16'h0002, 16'h0003, 16'h0004, 16'h0005, 1'b1, 16'h0006, 1'b1,
                 16'h0007, 16'h010C, 16'h0100, 1'b0, 1'b0);
        run_case(16'h0001, 16'h0002, 16'h0003, 16'h0004, 16'h0005, 1'b1, 16'h0006, 1'b1,
                 16'h0007, 16'h010A, 16'h0100, 1'b1, 1'b0);
        // R5 no-change stack: 3 words exact fit, then one byte short
        run_case(16'h0F00, 16'h0106, 16'h0000, 16'h0001, 16'h0002, 1'b0, 16'h0, 1'b0,
                 16'h0, 16'h0, 16'h0100, 1'b0, 1'b0);
        run_case(16'h0F00, 16'h0105, 16'h0000, 16'h0001, 16'h0002, 1'b0, 16'h0, 1'b0,
                 16'h0, 16'h0, 16'h0100, 1'b0, 1'b0);
        // R6 near wrap: pointer below floor
        run_case(16'h0F00, 16'h0004, 16'h0000, 16'h0001, 16'h0002, 1'b0, 16'h0, 1'b0,
                 16'h0, 16'h0, 16'hFFF0, 1'b1, 1'b0);
        // R9 start during a frame ignored
        run_case(16'hABCD, 16'h0400, 16'h1357, 16'h2468, 16'h9999, 1'b1, 16'h0F0F, 1'b1,
                 16'hBEEF, 16'h2000, 16'h0000, 1'b0, 1'b1);

        for (int i = 0; i < 150; i++) begin
            run_case(16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
                     16'($urandom), 1'($urandom), 16'($urandom), 1'($urandom),
                     16'($urandom), 16'($urandom), 16'($urandom % 32'h0400),
                     1'($urandom), (i % 10) == 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule